// File: doc/BRIEF.md
# Width-Configurable Cycle and Retire Counters

This block holds two free-running event counters for a processor core. One advances on every clock cycle. The other advances on every cycle in which the core reports a retired instruction. Software reads and writes each counter through two 32-bit register words, a low word and a high word, using a single-cycle request carrying an address, a write flag and write data. Read data and an illegal-access flag come back in the same cycle as the request.

The parameter `CNT_W` (0 to 64, default 64) sets the implemented width of each counter. Bits above that width read as zero and ignore writes. When `CNT_W` is 32 or less, the high-word registers are absent. When it is 0, all four registers are absent. An access to an absent register raises the illegal flag and changes nothing. Two constant status outputs tell the core whether the counters are narrowed or missing altogether.

Top module: `perf_ctr_pair`

## Requirements
- R1: Register addresses (12-bit) are: cycle low `0xB00`, retired low `0xB02`, cycle high `0xB80`, retired high `0xB82`. Read data is combinational and shows the counter value from before the next clock edge. A request to any other address, and any cycle without a request, gives read data 0, illegal flag 0 and no counter change.
- R2: Counter bits at or above `CNT_W` always read 0, and writes do not set them. For `CNT_W` of 32 to 63, `cnt_reduced_o` is 1.
- R3: For `CNT_W` of 1 to 31, a request to either high-word address raises `csr_illegal_o`, returns data 0 and changes no counter. `cnt_reduced_o` is 1.
- R4: For `CNT_W` of 0, a request to any of the four addresses raises `csr_illegal_o` with data 0, `cnt_absent_o` is 1 and `cnt_reduced_o` is 0. For `CNT_W` of 64, both status outputs are 0.
- R5: The cycle counter increases by one at every clock edge that is not a legal write to it.
- R6: The retire counter increases by one at every clock edge where `retire_i` is 1, unless that edge is a legal write to it.
- R7: A legal write replaces the implemented bits of the addressed word. The other word of that counter keeps its value. The counter does not count at that edge and continues from the written value at the next edge.
- R8: A counter at its all-ones value (within `CNT_W`) wraps to zero. A carry out of the low word reaches the high word at the same edge at which the low word wraps.
- R9: Reset is synchronous and active high. It clears both counters to zero, so the first read after reset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| retire_i | input | 1 | One instruction retired this cycle |
| csr_req_i | input | 1 | Register access request this cycle |
| csr_wr_i | input | 1 | Request is a write when 1, a read when 0 |
| csr_addr_i | input | 12 | Register address |
| csr_wdata_i | input | 32 | Write data |
| csr_rdata_o | output | 32 | Read data (current counter word) |
| csr_illegal_o | output | 1 | Request targeted an absent counter register |
| cnt_reduced_o | output | 1 | Counters narrower than 64 bits but present |
| cnt_absent_o | output | 1 | No counters implemented |

## Verification
The assertions assume at most one register access per cycle, with `csr_wr_i` meaningful only while `csr_req_i` is high. They also assume that inputs settle well before each rising edge, so that a write and a count never target the same word in one cycle other than as R7 defines. The stimulus changes every input only on the falling clock edge and issues one request per cycle. Four copies of the block, with widths 64, 40, 20 and 0, share the same stimulus, so wide, narrowed, high-less and absent configurations see identical write and retire patterns. The writes drive the counters next to their all-ones values so that the carry and wrap corners are reached in a few cycles.

// File: rtl/perf_ctr_pkg.sv
`timescale 1ns/1ps
package perf_ctr_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned FULL_W = 64;
    localparam int unsigned ADDR_W = 12;

    localparam logic [ADDR_W-1:0] ADDR_CYC_LO = 12'hB00;
    localparam logic [ADDR_W-1:0] ADDR_RET_LO = 12'hB02;
    localparam logic [ADDR_W-1:0] ADDR_CYC_HI = 12'hB80;
    localparam logic [ADDR_W-1:0] ADDR_RET_HI = 12'hB82;

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_CYC_LO,
        SEL_CYC_HI,
        SEL_RET_LO,
        SEL_RET_HI
    } csr_sel_e;

    typedef struct packed {
        csr_sel_e sel;
        logic     illegal;
    } csr_dec_t;

    typedef struct packed {
        logic lo;
        logic hi;
    } word_wr_t;

    function automatic csr_sel_e match_addr(input logic [ADDR_W-1:0] a);
        case (a)
            ADDR_CYC_LO: return SEL_CYC_LO;
            ADDR_CYC_HI: return SEL_CYC_HI;
            ADDR_RET_LO: return SEL_RET_LO;
            ADDR_RET_HI: return SEL_RET_HI;
            default:     return SEL_NONE;
        endcase
    endfunction

    function automatic logic is_high_word(input csr_sel_e s);
        return (s == SEL_CYC_HI) || (s == SEL_RET_HI);
    endfunction

    function automatic logic [FULL_W-1:0] width_mask(input int unsigned w);
        if (w >= FULL_W) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

endpackage

// File: rtl/perf_ctr_core.sv
`timescale 1ns/1ps
module perf_ctr_core
    import perf_ctr_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic                clk_i,
    input  logic                rst_i,
    input  logic                inc_i,
    input  word_wr_t            wr_i,
    input  logic [WORD_W-1:0]   wdata_i,
    output logic [FULL_W-1:0]   val_o
);

    localparam logic [FULL_W-1:0] FULL    = width_mask(CNT_W);
    localparam logic [WORD_W-1:0] LO_MASK = FULL[WORD_W-1:0];
    localparam logic [WORD_W-1:0] HI_MASK = FULL[FULL_W-1:WORD_W];

    logic [CNT_W-1:0]  cnt_q;
    logic [FULL_W-1:0] cur;
    logic [FULL_W-1:0] nxt;

    assign cur   = FULL_W'(cnt_q);
    assign val_o = cur;

    // Writes win over counting; the full-width add carries low into high.
    always_comb begin
        nxt = cur;
        if (wr_i.lo) begin
            nxt = {cur[FULL_W-1:WORD_W], wdata_i};
        end else if (wr_i.hi) begin
            nxt = {wdata_i, cur[WORD_W-1:0]};
        end else if (inc_i) begin
            nxt = cur + 64'd1;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= nxt[CNT_W-1:0];
        end
    end

    a_r7_low_write: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i.lo |=> val_o[WORD_W-1:0] == ($past(wdata_i) & LO_MASK));

    a_r7_high_write: assert property (@(posedge clk_i) disable iff (rst_i)
        wr_i.hi |=> val_o[FULL_W-1:WORD_W] == ($past(wdata_i) & HI_MASK));

    a_r8_wrap_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (inc_i && !wr_i.lo && !wr_i.hi && val_o == FULL) |=> val_o == '0);

    a_r5_step_one: assert property (@(posedge clk_i) disable iff (rst_i)
        (inc_i && !wr_i.lo && !wr_i.hi && val_o != FULL) |=> val_o == $past(val_o) + 64'd1);

    a_r6_hold_idle: assert property (@(posedge clk_i) disable iff (rst_i)
        (!inc_i && !wr_i.lo && !wr_i.hi) |=> $stable(val_o));

endmodule

// File: rtl/perf_ctr_decode.sv
`timescale 1ns/1ps
module perf_ctr_decode
    import perf_ctr_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic              req_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    output csr_dec_t          dec_o,
    output word_wr_t          cyc_wr_o,
    output word_wr_t          ret_wr_o
);

    localparam logic HAS_LO = (CNT_W > 0);
    localparam logic HAS_HI = (CNT_W > WORD_W);

    csr_sel_e hit_sel;
    logic     present;
    logic     wr_ok;

    always_comb begin
        hit_sel = match_addr(addr_i);
        present = is_high_word(hit_sel) ? HAS_HI : HAS_LO;

        dec_o.sel     = SEL_NONE;
        dec_o.illegal = 1'b0;
        if (req_i && hit_sel != SEL_NONE) begin
            if (present) dec_o.sel     = hit_sel;
            else         dec_o.illegal = 1'b1;
        end

        wr_ok       = req_i && wr_i;
        cyc_wr_o.lo = wr_ok && dec_o.sel == SEL_CYC_LO;
        cyc_wr_o.hi = wr_ok && dec_o.sel == SEL_CYC_HI;
        ret_wr_o.lo = wr_ok && dec_o.sel == SEL_RET_LO;
        ret_wr_o.hi = wr_ok && dec_o.sel == SEL_RET_HI;
    end

    a_r1_one_write: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0({cyc_wr_o.lo, cyc_wr_o.hi, ret_wr_o.lo, ret_wr_o.hi}));

    a_r3_high_absent: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !HAS_HI && (addr_i == ADDR_CYC_HI || addr_i == ADDR_RET_HI)) |-> dec_o.illegal);

    a_r4_all_absent: assert property (@(posedge clk_i) disable iff (rst_i)
        (req_i && !HAS_LO && match_addr(addr_i) != SEL_NONE) |-> dec_o.illegal);

    a_r3_no_write_when_illegal: assert property (@(posedge clk_i) disable iff (rst_i)
        dec_o.illegal |-> !(cyc_wr_o.lo || cyc_wr_o.hi || ret_wr_o.lo || ret_wr_o.hi));

endmodule

// File: rtl/perf_ctr_rdmux.sv
`timescale 1ns/1ps
module perf_ctr_rdmux
    import perf_ctr_pkg::*;
(
    input  csr_sel_e            sel_i,
    input  logic [FULL_W-1:0]   cyc_val_i,
    input  logic [FULL_W-1:0]   ret_val_i,
    output logic [WORD_W-1:0]   rdata_o
);

    always_comb begin
        unique case (sel_i)
            SEL_CYC_LO: rdata_o = cyc_val_i[WORD_W-1:0];
            SEL_CYC_HI: rdata_o = cyc_val_i[FULL_W-1:WORD_W];
            SEL_RET_LO: rdata_o = ret_val_i[WORD_W-1:0];
            SEL_RET_HI: rdata_o = ret_val_i[FULL_W-1:WORD_W];
            default:    rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/perf_ctr_pair.sv
`timescale 1ns/1ps
module perf_ctr_pair
    import perf_ctr_pkg::*;
#(
    parameter int unsigned CNT_W = 64
) (
    input  logic        clk_i,
    input  logic        rst_i,
    input  logic        retire_i,
    input  logic        csr_req_i,
    input  logic        csr_wr_i,
    input  logic [11:0] csr_addr_i,
    input  logic [31:0] csr_wdata_i,
    output logic [31:0] csr_rdata_o,
    output logic        csr_illegal_o,
    output logic        cnt_reduced_o,
    output logic        cnt_absent_o
);

    localparam logic [FULL_W-1:0] FULL    = width_mask(CNT_W);
    localparam logic [WORD_W-1:0] HI_MASK = FULL[FULL_W-1:WORD_W];

    csr_dec_t          dec;
    word_wr_t          cyc_wr;
    word_wr_t          ret_wr;
    logic [FULL_W-1:0] cyc_val;
    logic [FULL_W-1:0] ret_val;

    perf_ctr_decode #(.CNT_W(CNT_W)) u_decode (
        .clk_i    (clk_i),
        .rst_i    (rst_i),
        .req_i    (csr_req_i),
        .wr_i     (csr_wr_i),
        .addr_i   (csr_addr_i),
        .dec_o    (dec),
        .cyc_wr_o (cyc_wr),
        .ret_wr_o (ret_wr)
    );

    if (CNT_W > 0) begin : g_cnt
        perf_ctr_core #(.CNT_W(CNT_W)) u_cyc (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .inc_i   (1'b1),
            .wr_i    (cyc_wr),
            .wdata_i (csr_wdata_i),
            .val_o   (cyc_val)
        );
        perf_ctr_core #(.CNT_W(CNT_W)) u_ret (
            .clk_i   (clk_i),
            .rst_i   (rst_i),
            .inc_i   (retire_i),
            .wr_i    (ret_wr),
            .wdata_i (csr_wdata_i),
            .val_o   (ret_val)
        );
    end else begin : g_none
        assign cyc_val = '0;
        assign ret_val = '0;
    end

    perf_ctr_rdmux u_rdmux (
        .sel_i     (dec.sel),
        .cyc_val_i (cyc_val),
        .ret_val_i (ret_val),
        .rdata_o   (csr_rdata_o)
    );

    assign csr_illegal_o = dec.illegal;
    assign cnt_reduced_o = (CNT_W > 0) && (CNT_W < FULL_W);
    assign cnt_absent_o  = (CNT_W == 0);

    a_r1_illegal_no_data: assert property (@(posedge clk_i) disable iff (rst_i)
        csr_illegal_o |-> csr_rdata_o == '0);

    a_r1_idle_quiet: assert property (@(posedge clk_i) disable iff (rst_i)
        !csr_req_i |-> (!csr_illegal_o && csr_rdata_o == '0));

    a_r2_high_bits_zero: assert property (@(posedge clk_i) disable iff (rst_i)
        (csr_req_i && !csr_illegal_o && (csr_addr_i == ADDR_CYC_HI || csr_addr_i == ADDR_RET_HI))
            |-> (csr_rdata_o & ~HI_MASK) == '0);

    a_r9_reset_clear: assert property (@(posedge clk_i)
        $fell(rst_i) |-> (cyc_val == '0 && ret_val == '0));

endmodule

// File: tb/perf_ctr_pair_tb_top.sv
`timescale 1ns/1ps
module perf_ctr_pair_tb_top;

    localparam logic [11:0] A_CL = 12'hB00;
    localparam logic [11:0] A_RL = 12'hB02;
    localparam logic [11:0] A_CH = 12'hB80;
    localparam logic [11:0] A_RH = 12'hB82;
    localparam int WID [4] = '{64, 40, 20, 0};

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic        rst, retire, req, wr;
    logic [11:0] addr;
    logic [31:0] wdata;
    logic [31:0] rd  [4];
    logic        ill [4];
    logic        red [4];
    logic        absn[4];

    perf_ctr_pair #(.CNT_W(64)) dut_i (
        .clk_i(clk), .rst_i(rst), .retire_i(retire), .csr_req_i(req), .csr_wr_i(wr),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd[0]), .csr_illegal_o(ill[0]),
        .cnt_reduced_o(red[0]), .cnt_absent_o(absn[0]));
    perf_ctr_pair #(.CNT_W(40)) dut_w40_i (
        .clk_i(clk), .rst_i(rst), .retire_i(retire), .csr_req_i(req), .csr_wr_i(wr),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd[1]), .csr_illegal_o(ill[1]),
        .cnt_reduced_o(red[1]), .cnt_absent_o(absn[1]));
    perf_ctr_pair #(.CNT_W(20)) dut_w20_i (
        .clk_i(clk), .rst_i(rst), .retire_i(retire), .csr_req_i(req), .csr_wr_i(wr),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd[2]), .csr_illegal_o(ill[2]),
        .cnt_reduced_o(red[2]), .cnt_absent_o(absn[2]));
    perf_ctr_pair #(.CNT_W(0)) dut_w0_i (
        .clk_i(clk), .rst_i(rst), .retire_i(retire), .csr_req_i(req), .csr_wr_i(wr),
        .csr_addr_i(addr), .csr_wdata_i(wdata), .csr_rdata_o(rd[3]), .csr_illegal_o(ill[3]),
        .cnt_reduced_o(red[3]), .cnt_absent_o(absn[3]));

    typedef struct {
        int          dut;
        string       tag;
        logic [31:0] exp_d;
        logic        exp_ill;
    } item_t;

    item_t       sb[$];
    int          checks = 0;
    int          errors = 0;
    logic [63:0] m_cyc[4];
    logic [63:0] m_ret[4];
    logic [15:0] lfsr = 16'hACE1;

    function automatic logic [63:0] wmask(input int w);
        if (w >= 64) return '1;
        return (64'd1 << w) - 64'd1;
    endfunction

    task automatic check(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Driver: drive one cycle, push expected reads, advance the model for the coming edge.
    task automatic step(input string tag, input bit rq, input bit w, input logic [11:0] a,
                        input logic [31:0] d, input bit ret);
        req = rq; wr = w; addr = a; wdata = d; retire = ret;
        for (int i = 0; i < 4; i++) begin
            item_t       it;
            bit          known, is_hi, is_cyc, exists;
            logic [63:0] val, nc, nr;
            logic [31:0] word;
            known  = (a == A_CL) || (a == A_RL) || (a == A_CH) || (a == A_RH);
            is_hi  = (a == A_CH) || (a == A_RH);
            is_cyc = (a == A_CL) || (a == A_CH);
            exists = (WID[i] > 0) && (!is_hi || WID[i] > 32);
            val    = is_cyc ? m_cyc[i] : m_ret[i];
            word   = is_hi ? val[63:32] : val[31:0];
            it.dut     = i;
            it.tag     = tag;
            it.exp_d   = (rq && known && exists) ? word : 32'h0;
            it.exp_ill = rq && known && !exists;
            sb.push_back(it);
            nc = m_cyc[i] + 64'd1;
            nr = m_ret[i] + (ret ? 64'd1 : 64'd0);
            if (rq && w && known && exists) begin
                logic [63:0] nv;
                nv = is_hi ? {d, val[31:0]} : {val[63:32], d};
                if (is_cyc) nc = nv; else nr = nv;
            end
            m_cyc[i] = nc & wmask(WID[i]);
            m_ret[i] = nr & wmask(WID[i]);
        end
        @(negedge clk);
    endtask

    // Monitor: pop and compare everything pushed this cycle, well before the rising edge.
    initial begin
        forever begin
            @(negedge clk);
            #5;
            while (sb.size() > 0) begin
                item_t it;
                it = sb.pop_front();
                check(it.tag, $sformatf("rdata dut%0d", it.dut), rd[it.dut], it.exp_d);
                check(it.tag, $sformatf("illegal dut%0d", it.dut), {31'd0, ill[it.dut]}, {31'd0, it.exp_ill});
            end
        end
    end

    initial begin
        #(20 * 200000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    function automatic logic [11:0] pick_addr(input logic [2:0] s);
        case (s)
            3'd0, 3'd5: return A_CL;
            3'd1, 3'd6: return A_RL;
            3'd2:       return A_CH;
            3'd3, 3'd7: return A_RH;
            default:    return 12'h305;
        endcase
    endfunction

    initial begin
        rst = 1'b1; req = 1'b0; wr = 1'b0; addr = '0; wdata = '0; retire = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 4; i++) begin m_cyc[i] = '0; m_ret[i] = '0; end

        // R2 R3 R4: status outputs per width
        check("R4", "reduced w64", {31'd0, red[0]},  32'd0);
        check("R4", "absent w64",  {31'd0, absn[0]}, 32'd0);
        check("R2", "reduced w40", {31'd0, red[1]},  32'd1);
        check("R3", "reduced w20", {31'd0, red[2]},  32'd1);
        check("R4", "reduced w0",  {31'd0, red[3]},  32'd0);
        check("R4", "absent w0",   {31'd0, absn[3]}, 32'd1);

        // R9: first reads after reset are zero
        step("R9", 1, 0, A_CL, 0, 0);
        step("R9", 1, 0, A_RL, 0, 1);

        // R5 R6: counting under a retire pattern, all four addresses
        for (int k = 0; k < 24; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step((k % 2 == 0) ? "R5" : "R6", 1, 0, pick_addr(3'(k % 4)), 0, lfsr[0]);
        end

        // R7 R8: write low near all-ones, watch carry into the high word
        step("R7", 1, 1, A_CL, 32'hFFFF_FFF0, 0);
        for (int k = 0; k < 20; k++) step("R8", 1, 0, (k % 2 == 0) ? A_CL : A_CH, 0, 0);

        // R2 R8: write high all-ones (upper bits ignored when narrow), then full wrap
        step("R2", 1, 1, A_CH, 32'hFFFF_FFFF, 0);
        step("R2", 1, 0, A_CH, 0, 0);
        step("R8", 1, 1, A_CL, 32'hFFFF_FFFE, 0);
        for (int k = 0; k < 6; k++) step("R8", 1, 0, (k % 2 == 0) ? A_CL : A_CH, 0, 0);

        // R3: high write to retire counter, illegal and ignored when high word absent
        step("R3", 1, 1, A_RH, 32'h1234_5678, 1);
        step("R3", 1, 0, A_RH, 0, 0);
        step("R3", 1, 0, A_RL, 0, 0);

        // R7: write with retire asserted, counter holds the written value
        step("R7", 1, 1, A_RL, 32'h000F_FFFF, 1);
        step("R7", 1, 0, A_RL, 0, 1);
        step("R8", 1, 0, A_RL, 0, 1);
        step("R8", 1, 0, A_RH, 0, 0);

        // R1: unrelated address and idle cycles
        step("R1", 1, 1, 12'h305, 32'hDEAD_BEEF, 0);
        step("R1", 1, 0, 12'h305, 0, 0);
        step("R1", 0, 1, A_CL, 32'h0, 1);
        step("R1", 1, 0, A_CL, 0, 0);

        // R1 R7: mixed traffic
        for (int k = 0; k < 200; k++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step("R1", lfsr[7] | lfsr[3], (lfsr[5:4] == 2'b11), pick_addr(lfsr[10:8]),
                 {lfsr, lfsr ^ 16'h5A5A}, lfsr[1]);
        end

        step("R1", 0, 0, A_CL, 0, 0);
        @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule